// File: doc/BRIEF.md
# Character Display Register File

This block is the host-side storage of an eight-digit dot-matrix character display. A microprocessor writes to it over a parallel byte bus. The write is qualified by an active-low chip enable and an active-low write strobe. Where each byte lands depends on the top address bit and on an active-low flash-select input. With flash-select high and the top address bit set, the byte goes into one of the character words. With flash-select high and the top address bit clear, the byte becomes the control word. With flash-select low, bit 0 of the byte sets or clears the blink attribute of one digit. The low address bits pick the digit.

Each character word holds a 7-bit character code and a font-page select bit. The display scan logic reads these through one or more combinational read ports. Each port takes a digit index and returns that digit's code, page bit and blink bit. Reset fills every character word with the blank code (20h) and clears the blink bits and the control word. While reset is active, the block also drives a clear to the display timing counters.

Top module: `chr_disp_regfile`

## Requirements
- R1: While reset is active at a rising clock edge, every character word becomes 20h, every blink bit becomes 0 and the control word becomes 00h, starting with the next cycle.
- R2: A write with flash-select high and address bit 3 = 1 stores the full data byte into the character word selected by address bits 2..0.
- R3: A write with flash-select high and address bit 3 = 0 stores the full data byte into the control word. The control word appears on `ctrl_word` one cycle later.
- R4: A write with flash-select low sets the blink bit of the digit selected by address bits 2..0 to data bit 0, whatever the value of address bit 3. The character words and the control word stay unchanged.
- R5: A write happens only at a rising clock edge where both `ce_n` and `wr_n` are 0. If either is 1, all three stores hold their values.
- R6: A write attempted while reset is active has no effect. After reset is released, the stores show the reset values.
- R7: Each read port returns combinationally the following for the digit on its index input: bit 7 of the character word as `scan_page`, bits 6..0 as `scan_code`, and the digit's blink bit as `scan_flash`. The ports work independently of each other.
- R8: `tmr_clr` is 1 exactly while reset is active.
- R9: A character write or a blink write changes only the digit it addresses. The other seven digits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Active-high reset (synchronous by default) |
| host_addr | input | 4 | Bit 3 selects character or control; bits 2..0 select the digit |
| host_data | input | 8 | Write data byte |
| ce_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| fsel_n | input | 1 | Blink-memory select, active low |
| ctrl_word | output | 8 | Stored control word |
| tmr_clr | output | 1 | Clear to the display timing counters |
| scan_idx | input | 6 | Digit index for each read port, 3 bits per port |
| scan_code | output | 14 | 7-bit character code for each read port |
| scan_page | output | 2 | Font-page bit for each read port |
| scan_flash | output | 2 | Blink bit for each read port |

## Verification
The bench builds the block with its default geometry: eight digits, a 4-bit address, byte-wide data and synchronous reset. It raises the number of read ports to two. With two ports, a scan of all eight digits compares two different digits at each step, so port crosstalk and index mix-ups become visible. Directed cases place page-bit-set codes, blink writes with both values of address bit 3, and writes at digit 0 and digit 7. Random traffic also asserts reset at random, so writes that coincide with reset get exercised.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

   // Where a qualified host write is steered
   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_CHAR  = 2'd1,
      TGT_CTRL  = 2'd2,
      TGT_FLASH = 2'd3
   } cdr_tgt_e;

   localparam logic [7:0] BLANK_CODE = 8'h20;

   function automatic cdr_tgt_e steer(input logic ce_n, input logic wr_n,
                                      input logic fsel_n, input logic mode);
      cdr_tgt_e t;
      if (ce_n || wr_n)  t = TGT_NONE;
      else if (!fsel_n)  t = TGT_FLASH;
      else if (mode)     t = TGT_CHAR;
      else               t = TGT_CTRL;
      return t;
   endfunction

endpackage

// File: rtl/cdr_addr_dec.sv
module cdr_addr_dec #(
   parameter int ADDR_W = 4,
   parameter int IDX_W  = 3
) (
   input  logic              ce_n,
   input  logic              wr_n,
   input  logic              fsel_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              char_we,
   output logic              ctrl_we,
   output logic              flash_we,
   output logic [IDX_W-1:0]  idx
);
   import cdr_pkg::*;

   localparam int MODE_BIT = ADDR_W - 1;

   cdr_tgt_e tgt;

   always_comb begin
      tgt      = steer(ce_n, wr_n, fsel_n, addr[MODE_BIT]);
      char_we  = (tgt == TGT_CHAR);
      ctrl_we  = (tgt == TGT_CTRL);
      flash_we = (tgt == TGT_FLASH);
      idx      = addr[IDX_W-1:0];
   end

endmodule

// File: rtl/cdr_reg_bank.sv
module cdr_reg_bank #(
   parameter int             DEPTH     = 8,
   parameter int             WIDTH     = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0,
   parameter bit             ASYNC_RST = 1'b0,
   localparam int            AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   we,
   input  logic [AW-1:0]          wr_idx,
   input  logic [WIDTH-1:0]       wr_data,
   output logic [DEPTH*WIDTH-1:0] flat_q
);

   logic [WIDTH-1:0] mem_q [DEPTH];

   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
            end else if (we) begin
               mem_q[wr_idx] <= wr_data;
            end
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
            end else if (we) begin
               mem_q[wr_idx] <= wr_data;
            end
         end
      end
   endgenerate

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_flat
         assign flat_q[g*WIDTH +: WIDTH] = mem_q[g];
      end
   endgenerate

endmodule

// File: rtl/cdr_scan_port.sv
module cdr_scan_port #(
   parameter int DIGITS = 8,
   parameter int DATA_W = 8,
   localparam int IDX_W  = $clog2(DIGITS),
   localparam int CODE_W = DATA_W - 1
) (
   input  logic [DIGITS*DATA_W-1:0] char_flat,
   input  logic [DIGITS-1:0]        flash_flat,
   input  logic [IDX_W-1:0]         idx,
   output logic [CODE_W-1:0]        code,
   output logic                     page,
   output logic                     flash
);

   logic [DATA_W-1:0] word;

   always_comb begin
      word  = char_flat[idx*DATA_W +: DATA_W];
      code  = word[CODE_W-1:0];
      page  = word[DATA_W-1];
      flash = flash_flat[idx];
   end

endmodule

// File: rtl/chr_disp_regfile.sv
module chr_disp_regfile #(
   parameter int          DIGITS     = 8,
   parameter int          DATA_W     = 8,
   parameter int          ADDR_W     = 4,
   parameter int          READ_PORTS = 1,
   parameter bit          ASYNC_RST  = 1'b0,
   parameter logic [DATA_W-1:0] BLANK = DATA_W'(cdr_pkg::BLANK_CODE),
   localparam int         IDX_W      = $clog2(DIGITS),
   localparam int         CODE_W     = DATA_W - 1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [ADDR_W-1:0]            host_addr,
   input  logic [DATA_W-1:0]            host_data,
   input  logic                         ce_n,
   input  logic                         wr_n,
   input  logic                         fsel_n,
   output logic [DATA_W-1:0]            ctrl_word,
   output logic                         tmr_clr,
   input  logic [READ_PORTS*IDX_W-1:0]  scan_idx,
   output logic [READ_PORTS*CODE_W-1:0] scan_code,
   output logic [READ_PORTS-1:0]        scan_page,
   output logic [READ_PORTS-1:0]        scan_flash
);

   // Elaboration-time parameter checks
   generate
      if (DIGITS < 2 || (1 << IDX_W) != DIGITS) begin : g_bad_digits
         $error("DIGITS must be a power of two, at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed the digit index width");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must hold a code and a page bit");
      end
      if (READ_PORTS < 1) begin : g_bad_ports
         $error("READ_PORTS must be at least 1");
      end
   endgenerate

   logic               char_we, ctrl_we, flash_we;
   logic [IDX_W-1:0]   wr_idx;
   logic [DIGITS*DATA_W-1:0] char_flat;
   logic [DIGITS-1:0]  flash_flat;

   cdr_addr_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
      .ce_n     (ce_n),
      .wr_n     (wr_n),
      .fsel_n   (fsel_n),
      .addr     (host_addr),
      .char_we  (char_we),
      .ctrl_we  (ctrl_we),
      .flash_we (flash_we),
      .idx      (wr_idx)
   );

   cdr_reg_bank #(.DEPTH(DIGITS), .WIDTH(DATA_W), .RST_VAL(BLANK),
                  .ASYNC_RST(ASYNC_RST)) u_chars (
      .clk     (clk),
      .rst     (rst),
      .we      (char_we),
      .wr_idx  (wr_idx),
      .wr_data (host_data),
      .flat_q  (char_flat)
   );

   cdr_reg_bank #(.DEPTH(DIGITS), .WIDTH(1), .RST_VAL(1'b0),
                  .ASYNC_RST(ASYNC_RST)) u_flash (
      .clk     (clk),
      .rst     (rst),
      .we      (flash_we),
      .wr_idx  (wr_idx),
      .wr_data (host_data[0]),
      .flat_q  (flash_flat)
   );

   cdr_reg_bank #(.DEPTH(1), .WIDTH(DATA_W), .RST_VAL('0),
                  .ASYNC_RST(ASYNC_RST)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .we      (ctrl_we),
      .wr_idx  (1'b0),
      .wr_data (host_data),
      .flat_q  (ctrl_word)
   );

   assign tmr_clr = rst;

   generate
      for (genvar p = 0; p < READ_PORTS; p++) begin : g_port
         cdr_scan_port #(.DIGITS(DIGITS), .DATA_W(DATA_W)) u_port (
            .char_flat  (char_flat),
            .flash_flat (flash_flat),
            .idx        (scan_idx[p*IDX_W +: IDX_W]),
            .code       (scan_code[p*CODE_W +: CODE_W]),
            .page       (scan_page[p]),
            .flash      (scan_flash[p])
         );
      end
   endgenerate

endmodule

// File: rtl/cdr_chk.sv
module cdr_chk #(
   parameter int DIGITS = 8,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter logic [DATA_W-1:0] BLANK = 8'h20,
   localparam int IDX_W = $clog2(DIGITS)
) (
   input logic                     clk,
   input logic                     rst,
   input logic [ADDR_W-1:0]        host_addr,
   input logic [DATA_W-1:0]        host_data,
   input logic                     ce_n,
   input logic                     wr_n,
   input logic                     fsel_n,
   input logic [DATA_W-1:0]        ctrl_word,
   input logic [DIGITS*DATA_W-1:0] char_flat,
   input logic [DIGITS-1:0]        flash_flat
);

   logic             wr_any, wr_char, wr_ctrl, wr_flash;
   logic [IDX_W-1:0] a_idx;

   assign wr_any   = !ce_n && !wr_n;
   assign wr_flash = wr_any && !fsel_n;
   assign wr_char  = wr_any && fsel_n && host_addr[ADDR_W-1];
   assign wr_ctrl  = wr_any && fsel_n && !host_addr[ADDR_W-1];
   assign a_idx    = host_addr[IDX_W-1:0];

   // R1
   rst_ctrl_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (ctrl_word == '0 && flash_flat == '0
                      && char_flat == {DIGITS{BLANK}}));

   // R2
   char_store_chk: assert property (@(posedge clk) disable iff (rst)
      wr_char |=> char_flat[$past(a_idx)*DATA_W +: DATA_W] == $past(host_data));

   // R3
   ctrl_store_chk: assert property (@(posedge clk) disable iff (rst)
      wr_ctrl |=> ctrl_word == $past(host_data));

   // R4
   flash_isolated_chk: assert property (@(posedge clk) disable iff (rst)
      wr_flash |=> ($stable(ctrl_word) && $stable(char_flat)
                    && flash_flat[$past(a_idx)] == $past(host_data[0])));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_any |=> ($stable(ctrl_word) && $stable(char_flat) && $stable(flash_flat)));

endmodule

bind chr_disp_regfile cdr_chk #(
   .DIGITS(DIGITS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLANK(BLANK)
) u_cdr_chk (
   .clk        (clk),
   .rst        (rst),
   .host_addr  (host_addr),
   .host_data  (host_data),
   .ce_n       (ce_n),
   .wr_n       (wr_n),
   .fsel_n     (fsel_n),
   .ctrl_word  (ctrl_word),
   .char_flat  (char_flat),
   .flash_flat (flash_flat)
);

// File: tb/tb_chr_disp_regfile.sv
`timescale 1ns/1ps
module tb_chr_disp_regfile;

   localparam int NP = 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  host_addr = '0;
   logic [7:0]  host_data = '0;
   logic        ce_n = 1'b1, wr_n = 1'b1, fsel_n = 1'b1;
   logic [7:0]  ctrl_word;
   logic        tmr_clr;
   logic [5:0]  scan_idx = '0;
   logic [13:0] scan_code;
   logic [1:0]  scan_page, scan_flash;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [7:0] m_char [8];
   logic       m_flash [8];
   logic [7:0] m_ctrl;

   always #10 clk = ~clk;

   chr_disp_regfile #(.READ_PORTS(NP)) dut (
      .clk(clk), .rst(rst), .host_addr(host_addr), .host_data(host_data),
      .ce_n(ce_n), .wr_n(wr_n), .fsel_n(fsel_n), .ctrl_word(ctrl_word),
      .tmr_clr(tmr_clr), .scan_idx(scan_idx), .scan_code(scan_code),
      .scan_page(scan_page), .scan_flash(scan_flash)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic void model_reset();
      for (int i = 0; i < 8; i++) begin m_char[i] = 8'h20; m_flash[i] = 1'b0; end
      m_ctrl = 8'h00;
   endfunction

   // Model of one rising edge, from the requirements
   function automatic void model_edge(input logic r, input logic [3:0] a, input logic [7:0] d,
                                      input logic c, input logic w, input logic f);
      if (r) model_reset();
      else if (!c && !w) begin
         if (!f)        m_flash[a[2:0]] = d[0];
         else if (a[3]) m_char[a[2:0]]  = d;
         else           m_ctrl          = d;
      end
   endfunction

   // Drive at negedge, apply at posedge, model follows
   task automatic cycle(input logic r, input logic [3:0] a, input logic [7:0] d,
                        input logic c, input logic w, input logic f);
      @(negedge clk);
      rst = r; host_addr = a; host_data = d; ce_n = c; wr_n = w; fsel_n = f;
      @(posedge clk);
      model_edge(r, a, d, c, w, f);
      #2;
   endtask

   // R7: port 0 reads digit k while port 1 reads digit 7-k
   task automatic scan_all(input string req);
      @(negedge clk);
      ce_n = 1'b1; wr_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
         scan_idx = {3'(7 - k), 3'(k)};
         #1;
         check(req, {scan_page[0], scan_code[6:0], scan_flash[0]},
               {m_char[k][7], m_char[k][6:0], m_flash[k]});
         check(req, {scan_page[1], scan_code[13:7], scan_flash[1]},
               {m_char[7-k][7], m_char[7-k][6:0], m_flash[7-k]});
      end
      check(req, ctrl_word, m_ctrl);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5580));
      model_reset();
      // R8: clear follows reset
      #5 check("R8", tmr_clr, 1'b1);
      cycle(1'b1, 4'h8, 8'h55, 1'b1, 1'b1, 1'b1);
      // R6: writes during reset ignored
      cycle(1'b1, 4'h9, 8'hC1, 1'b0, 1'b0, 1'b1);
      cycle(1'b1, 4'h0, 8'hAA, 1'b0, 1'b0, 1'b1);
      cycle(1'b1, 4'h3, 8'h01, 1'b0, 1'b0, 1'b0);
      model_reset();
      cycle(1'b0, 4'h0, 8'h00, 1'b1, 1'b1, 1'b1);
      check("R8", tmr_clr, 1'b0);
      scan_all("R1 R6 reset state");

      // R2 R7 R9: edge digits and page bit
      cycle(1'b0, 4'h8, 8'hC1, 1'b0, 1'b0, 1'b1);
      cycle(1'b0, 4'hF, 8'h7E, 1'b0, 1'b0, 1'b1);
      cycle(1'b0, 4'hC, 8'hB3, 1'b0, 1'b0, 1'b1);
      scan_all("R2 R7 R9 char write");

      // R3: control word
      cycle(1'b0, 4'h5, 8'hA5, 1'b0, 1'b0, 1'b1);
      check("R3", ctrl_word, 8'hA5);

      // R4: blink writes with both address bit 3 values
      cycle(1'b0, 4'h7, 8'hFF, 1'b0, 1'b0, 1'b0);
      cycle(1'b0, 4'hA, 8'h01, 1'b0, 1'b0, 1'b0);
      cycle(1'b0, 4'h7, 8'hFE, 1'b0, 1'b0, 1'b0);
      cycle(1'b0, 4'h0, 8'h03, 1'b0, 1'b0, 1'b0);
      scan_all("R4 R9 blink write");
      check("R4", ctrl_word, 8'hA5);

      // R5: half-qualified strobes
      cycle(1'b0, 4'h8, 8'h11, 1'b1, 1'b0, 1'b1);
      cycle(1'b0, 4'h1, 8'h22, 1'b0, 1'b1, 1'b1);
      cycle(1'b0, 4'h2, 8'h01, 1'b1, 1'b0, 1'b0);
      scan_all("R5 unqualified write");

      // Random traffic with occasional reset
      for (int n = 0; n < 600; n++) begin
         logic r, c, w, f;
         r = ($urandom % 40) == 0;
         c = ($urandom % 4) == 0;
         w = ($urandom % 4) == 0;
         f = ($urandom % 3) != 0;
         cycle(r, 4'($urandom), 8'($urandom), c, w, f);
         check("R3 R5 random ctrl", ctrl_word, m_ctrl);
         check("R8 random", tmr_clr, r);
         if (n % 20 == 19) scan_all("R2 R4 R7 random");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule